// File: doc/BRIEF.md
# Power Management Event and Sleep Controller

This block collects five power-management events and keeps a sticky status bit and an enable bit for each. The events are a timer overflow, a serial ring indicator, a network wake line, a power button and a real-time-clock alarm. Any event that is both latched and enabled raises one interrupt level. A global routing bit sends that interrupt to either the SCI output or the SMI output. Software reads and writes the registers over a small synchronous bus. Status bits clear when software writes 1 to them.

The block also tracks the processor's idle depth. The C-state FSM has four states, `CS_C0` to `CS_C3`. It moves from `CS_C0` to `CS_C1` on a halt pulse, to `CS_C2` on a read of the level-2 address and to `CS_C3` on a read of the level-3 address. It returns to `CS_C0` on the transition named *break*: any enabled pending event, or a write to the control register.

The power FSM has four states: `PW_WORK` (working), `PW_S1` (light sleep), `PW_S3` (deep sleep) and `PW_OFF` (soft-off). The transition *enter* leaves `PW_WORK` when software writes the sleep-enable bit together with a recognised sleep code. The transition *wake* returns any sleep state to `PW_WORK` when a wake-class event is latched and enabled. Three active-low outputs report the sleep depth, and each deeper state also asserts the shallower outputs.

Top module: `pm_event_ctrl`

## Requirements
- R1: A status bit is set only by its event. Writing address 0 with a 1 in a bit position clears that bit. If an event sets a bit in the same cycle that software clears it, the set wins. Reading address 0 returns status in bits [4:0]: bit 0 timer overflow, bit 1 ring indicator, bit 2 network wake, bit 3 power button, bit 4 RTC alarm.
- R2: The enable register is written and read at address 1, using the same bit layout as status.
- R3: When any bit is set in both status and enable, `sci` is high if routing bit 0 of the control register is 1, and `smi` is high if it is 0. When no bit is set in both, neither output is high.
- R4: `ring_in` and `pwr_btn` pass through a two-flop synchronizer and a rising-edge detector. A rise on either input sets its status bit on the third rising clock edge after the rise. Holding the input high sets the bit only once.
- R5: `tmr_ovf`, `lan_wake` and `rtc_alarm` are synchronous. A high level sampled on a clock edge sets the matching status bit on that same edge.
- R6: While the power state is working and the C-state is C0, the C-state changes as follows. A halt moves it to C1. A read of address 3 moves it to C2. A read of address 4 moves it to C3. A read takes priority over a halt in the same cycle. `cstate` encodes C0 to C3 as 0 to 3.
- R7: From C1, C2 or C3, the C-state returns to C0 on the edge after any status bit that is also enabled, or after any write to address 2. Outside the working state the C-state is held at C0.
- R8: The control register is at address 2. Bit 0 is routing and bits [3:1] are the sleep code. Bit 4 is sleep-enable and always reads as 0. In the working state, a write with bit 4 set enters a sleep state on the same edge: code 010 gives light sleep, 101 gives deep sleep and 111 gives soft-off. Any other code leaves the block working. A sleep-enable write in a sleep state is ignored.
- R9: `pwr_state` encodes working, light sleep, deep sleep and soft-off as 0 to 3. `sus_lite_n` is low in all three sleep states. `sus_deep_n` is low in deep sleep and soft-off. `soft_off_n` is low only in soft-off.
- R10: In any sleep state, a status bit among bits 1 to 4 that is also enabled returns the block to working on the next edge. Its status bit stays set. Timer overflow never wakes the block.
- R11: Reset clears every register. The block starts working in C0, with all three sleep outputs high, `sci` and `smi` low, and reads of any address returning 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset (standby power-on) |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational, 0 when `bus_rd` is low |
| cpu_halt | input | 1 | Processor halt pulse |
| tmr_ovf | input | 1 | Timer overflow pulse, synchronous |
| ring_in | input | 1 | Serial ring indicator, asynchronous |
| lan_wake | input | 1 | Network wake pulse, synchronous |
| pwr_btn | input | 1 | Power button, asynchronous, active high |
| rtc_alarm | input | 1 | RTC alarm match pulse, synchronous |
| sci | output | 1 | Event interrupt routed to SCI |
| smi | output | 1 | Event interrupt routed to SMI |
| cstate | output | 2 | Processor C-state |
| pwr_state | output | 2 | Power state |
| sus_lite_n | output | 1 | Low in any sleep state |
| sus_deep_n | output | 1 | Low in deep sleep or soft-off |
| soft_off_n | output | 1 | Low in soft-off |

## Verification
Two pairs of functions can act in the same cycle, and the bench drives both on one edge.

The first pair is an event and a software clear on the same status bit. The bench pulses `lan_wake` in the same cycle as a write of 1 to bit 2 of address 0. The set must win, so bit 2 reads back as 1 afterwards.

The second pair is a halt and a level-2 read in the same cycle. The read has priority, so the C-state must land in C2 and not C1.

The behavioural model in the bench applies the same priorities. It compares every output on every cycle, so a lost event or a wrong C-state shows up in the cycle where it happens.

// File: rtl/pm_pkg.sv
package pm_pkg;
    localparam int N_EVT = 5;
    localparam int EV_TMR = 0;
    localparam int EV_RING = 1;
    localparam int EV_LAN = 2;
    localparam int EV_BTN = 3;
    localparam int EV_RTC = 4;
    localparam logic [N_EVT-1:0] WAKE_MASK = 5'b11110;

    localparam logic [2:0] A_STS  = 3'd0;
    localparam logic [2:0] A_EN   = 3'd1;
    localparam logic [2:0] A_CTL  = 3'd2;
    localparam logic [2:0] A_LVL2 = 3'd3;
    localparam logic [2:0] A_LVL3 = 3'd4;

    localparam logic [2:0] CODE_S1  = 3'b010;
    localparam logic [2:0] CODE_S3  = 3'b101;
    localparam logic [2:0] CODE_OFF = 3'b111;

    typedef enum logic [1:0] {PW_WORK = 2'd0, PW_S1 = 2'd1, PW_S3 = 2'd2, PW_OFF = 2'd3} pwr_e;
    typedef enum logic [1:0] {CS_C0 = 2'd0, CS_C1 = 2'd1, CS_C2 = 2'd2, CS_C3 = 2'd3} cst_e;
endpackage

// File: rtl/pm_edge_sync.sv
module pm_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic rise
);
    logic [STAGES:0] sh;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh <= '0;
        else        sh <= {sh[STAGES-1:0], din};
    end

    assign rise = sh[STAGES-1] & ~sh[STAGES];

    // R4: a detected edge lasts one cycle
    p_single_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> !rise);
endmodule

// File: rtl/pm_event_regs.sv
module pm_event_regs #(
    parameter int NE = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NE-1:0] set_vec,
    input  logic          wr_sts,
    input  logic          wr_enr,
    input  logic [NE-1:0] wbits,
    output logic [NE-1:0] sts,
    output logic [NE-1:0] en
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sts <= '0;
        end else if (wr_sts) begin
            sts <= (sts & ~wbits) | set_vec;
        end else begin
            sts <= sts | set_vec;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      en <= '0;
        else if (wr_enr) en <= wbits;
    end

    // R1: write-one clears when no event coincides
    p_w1c_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_sts && wbits[0] && !set_vec[0]) |=> !sts[0]);
    // R1: an event always leaves its bit set
    p_hw_wins_r1: assert property (@(posedge clk) disable iff (!rst_n)
        set_vec[2] |=> sts[2]);
endmodule

// File: rtl/pm_cstate.sv
module pm_cstate
    import pm_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic in_work,
    input  logic halt,
    input  logic lvl2,
    input  logic lvl3,
    input  logic brk,
    output cst_e cs
);
    cst_e cs_nxt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cs <= CS_C0;
        else        cs <= cs_nxt;
    end

    always_comb begin
        cs_nxt = cs;
        if (!in_work) begin
            cs_nxt = CS_C0;
        end else begin
            unique case (cs)
                CS_C0: begin
                    if (lvl3)      cs_nxt = CS_C3;
                    else if (lvl2) cs_nxt = CS_C2;
                    else if (halt) cs_nxt = CS_C1;
                end
                CS_C1, CS_C2, CS_C3: if (brk) cs_nxt = CS_C0;
                default: cs_nxt = CS_C0;
            endcase
        end
    end

    // R7: held at C0 outside the working state
    p_c0_asleep_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !in_work |=> cs == CS_C0);
    // R6: lone halt in C0 enters C1
    p_halt_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_work && cs == CS_C0 && halt && !lvl2 && !lvl3) |=> cs == CS_C1);
endmodule

// File: rtl/pm_sleep_fsm.sv
module pm_sleep_fsm
    import pm_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sleep_cmd,
    input  logic [2:0] code,
    input  logic       wake,
    output pwr_e       st,
    output logic       lite_n,
    output logic       deep_n,
    output logic       off_n
);
    pwr_e st_nxt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= PW_WORK;
        else        st <= st_nxt;
    end

    always_comb begin
        st_nxt = st;
        unique case (st)
            PW_WORK: begin
                if (sleep_cmd) begin
                    if (code == CODE_S1)       st_nxt = PW_S1;
                    else if (code == CODE_S3)  st_nxt = PW_S3;
                    else if (code == CODE_OFF) st_nxt = PW_OFF;
                end
            end
            PW_S1, PW_S3, PW_OFF: if (wake) st_nxt = PW_WORK;
            default: st_nxt = PW_WORK;
        endcase
    end

    always_comb begin
        lite_n = 1'b1;
        deep_n = 1'b1;
        off_n  = 1'b1;
        unique case (st)
            PW_WORK: ;
            PW_S1:   lite_n = 1'b0;
            PW_S3:   begin lite_n = 1'b0; deep_n = 1'b0; end
            PW_OFF:  begin lite_n = 1'b0; deep_n = 1'b0; off_n = 1'b0; end
            default: ;
        endcase
    end

    // R10: enabled wake leaves any sleep state
    p_wake_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (st != PW_WORK && wake) |=> st == PW_WORK);
    // R8: reserved code keeps the block working
    p_reserved_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (st == PW_WORK && sleep_cmd && code != CODE_S1 && code != CODE_S3
         && code != CODE_OFF) |=> st == PW_WORK);
endmodule

// File: rtl/pm_event_ctrl.sv
module pm_event_ctrl
    import pm_pkg::*;
#(
    parameter int ADDR_W = 3,
    parameter int DATA_W = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              cpu_halt,
    input  logic              tmr_ovf,
    input  logic              ring_in,
    input  logic              lan_wake,
    input  logic              pwr_btn,
    input  logic              rtc_alarm,
    output logic              sci,
    output logic              smi,
    output logic [1:0]        cstate,
    output logic [1:0]        pwr_state,
    output logic              sus_lite_n,
    output logic              sus_deep_n,
    output logic              soft_off_n
);
    localparam int N_ASYNC = 2;
    localparam int SLP_BIT = 4;

    logic [N_ASYNC-1:0] async_in, async_rise;
    logic [N_EVT-1:0]   set_vec, sts, en, hit;
    logic               wr_sts, wr_enr, wr_ctl, rd_l2, rd_l3;
    logic               route_sci;
    logic [2:0]         slp_code;
    logic               pending, wake_req;
    pwr_e               pst;
    cst_e               cst;
    logic               unused_bits;

    assign unused_bits = ^bus_wdata[DATA_W-1:N_EVT];

    assign async_in = {pwr_btn, ring_in};
    for (genvar g = 0; g < N_ASYNC; g++) begin : g_sync
        pm_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk(clk), .rst_n(rst_n), .din(async_in[g]), .rise(async_rise[g]));
    end

    always_comb begin
        set_vec          = '0;
        set_vec[EV_TMR]  = tmr_ovf;
        set_vec[EV_RING] = async_rise[0];
        set_vec[EV_LAN]  = lan_wake;
        set_vec[EV_BTN]  = async_rise[1];
        set_vec[EV_RTC]  = rtc_alarm;
    end

    assign wr_sts = bus_wr && bus_addr == A_STS;
    assign wr_enr = bus_wr && bus_addr == A_EN;
    assign wr_ctl = bus_wr && bus_addr == A_CTL;
    assign rd_l2  = bus_rd && bus_addr == A_LVL2;
    assign rd_l3  = bus_rd && bus_addr == A_LVL3;

    pm_event_regs #(.NE(N_EVT)) u_regs (
        .clk(clk), .rst_n(rst_n), .set_vec(set_vec), .wr_sts(wr_sts),
        .wr_enr(wr_enr), .wbits(bus_wdata[N_EVT-1:0]), .sts(sts), .en(en));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            route_sci <= 1'b0;
            slp_code  <= '0;
        end else if (wr_ctl) begin
            route_sci <= bus_wdata[0];
            slp_code  <= bus_wdata[3:1];
        end
    end

    assign hit      = sts & en;
    assign pending  = |hit;
    assign wake_req = |(hit & WAKE_MASK);
    assign sci      = pending & route_sci;
    assign smi      = pending & ~route_sci;

    pm_cstate u_cst (
        .clk(clk), .rst_n(rst_n), .in_work(pst == PW_WORK), .halt(cpu_halt),
        .lvl2(rd_l2), .lvl3(rd_l3), .brk(pending | wr_ctl), .cs(cst));

    pm_sleep_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .sleep_cmd(wr_ctl && bus_wdata[SLP_BIT]),
        .code(bus_wdata[3:1]), .wake(wake_req), .st(pst),
        .lite_n(sus_lite_n), .deep_n(sus_deep_n), .off_n(soft_off_n));

    assign cstate    = cst;
    assign pwr_state = pst;

    always_comb begin
        bus_rdata = '0;
        if (bus_rd) begin
            unique case (bus_addr)
                A_STS:   bus_rdata[N_EVT-1:0] = sts;
                A_EN:    bus_rdata[N_EVT-1:0] = en;
                A_CTL:   bus_rdata[3:0] = {slp_code, route_sci};
                default: bus_rdata = '0;
            endcase
        end
    end

    // R3: the two interrupt outputs never coincide
    p_route_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(sci && smi));
    // R8: sleep-enable never reads back
    p_slp_rd0_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == A_CTL) |-> !bus_rdata[SLP_BIT]);
endmodule

// File: tb/sim_pm_event_ctrl.sv
module sim_pm_event_ctrl;
    localparam int PERIOD = 10;
    localparam int WATCHDOG = 20000;

    logic clk = 1'b0, rst_n = 1'b0;
    logic bus_wr = 0, bus_rd = 0;
    logic [2:0] bus_addr = 0;
    logic [7:0] bus_wdata = 0;
    logic [7:0] bus_rdata;
    logic cpu_halt = 0, tmr_ovf = 0, ring_in = 0, lan_wake = 0, pwr_btn = 0, rtc_alarm = 0;
    logic sci, smi, sus_lite_n, sus_deep_n, soft_off_n;
    logic [1:0] cstate, pwr_state;

    int checks = 0, fails = 0, cyc = 0;
    bit done = 0;

    pm_event_ctrl u0 (.*);

    always #(PERIOD/2) clk = ~clk;

    // behavioural reference
    int m_sts, m_en, m_sel, m_typ, m_pwr, m_cs;
    int rq[$], bq[$];

    function automatic int bitof(int v, int b); return (v >> b) & 1; endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_sts = 0; m_en = 0; m_sel = 0; m_typ = 0; m_pwr = 0; m_cs = 0;
            rq = '{0, 0, 0}; bq = '{0, 0, 0};
        end else begin
            int set, hit, wk, ns, npwr, ncs, re, be;
            re = (rq[1] == 1 && rq[2] == 0) ? 1 : 0;
            be = (bq[1] == 1 && bq[2] == 0) ? 1 : 0;
            set = int'(tmr_ovf) | (re << 1) | (int'(lan_wake) << 2) | (be << 3) | (int'(rtc_alarm) << 4);
            hit = m_sts & m_en;
            wk = hit & 'h1e;
            ns = m_sts | set;
            if (bus_wr && bus_addr == 0) ns = (m_sts & ~int'(bus_wdata[4:0])) | set;
            npwr = m_pwr;
            if (m_pwr != 0) begin
                if (wk != 0) npwr = 0;
            end else if (bus_wr && bus_addr == 2 && bus_wdata[4]) begin
                case (int'(bus_wdata[3:1]))
                    2: npwr = 1;
                    5: npwr = 2;
                    7: npwr = 3;
                    default: npwr = 0;
                endcase
            end
            ncs = m_cs;
            if (m_pwr != 0) ncs = 0;
            else if (m_cs == 0) begin
                if (bus_rd && bus_addr == 4) ncs = 3;
                else if (bus_rd && bus_addr == 3) ncs = 2;
                else if (cpu_halt) ncs = 1;
            end else if (hit != 0 || (bus_wr && bus_addr == 2)) ncs = 0;
            if (bus_wr && bus_addr == 1) m_en = int'(bus_wdata[4:0]);
            if (bus_wr && bus_addr == 2) begin
                m_sel = int'(bus_wdata[0]);
                m_typ = int'(bus_wdata[3:1]);
            end
            m_sts = ns; m_pwr = npwr; m_cs = ncs;
            rq.push_front(int'(ring_in)); void'(rq.pop_back());
            bq.push_front(int'(pwr_btn)); void'(bq.pop_back());
        end
    end

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s cycle %0d: actual %0d expected %0d", tag, cyc, act, exp);
        end
    endtask

    task automatic compare();
        int pend, erd;
        pend = ((m_sts & m_en) != 0) ? 1 : 0;
        erd = 0;
        if (bus_rd) begin
            if (bus_addr == 0) erd = m_sts;
            else if (bus_addr == 1) erd = m_en;
            else if (bus_addr == 2) erd = (m_typ << 1) | m_sel;
        end
        if (bus_addr == 0) chk("R1/R4/R5 rdata", int'(bus_rdata), erd);
        else if (bus_addr == 1) chk("R2 rdata", int'(bus_rdata), erd);
        else chk("R8 rdata", int'(bus_rdata), erd);
        chk("R3 sci", int'(sci), pend & m_sel);
        chk("R3 smi", int'(smi), pend & (1 - m_sel));
        chk("R6/R7 cstate", int'(cstate), m_cs);
        chk("R8/R10 pwr_state", int'(pwr_state), m_pwr);
        chk("R9 sus_lite_n", int'(sus_lite_n), (m_pwr >= 1) ? 0 : 1);
        chk("R9 sus_deep_n", int'(sus_deep_n), (m_pwr >= 2) ? 0 : 1);
        chk("R9 soft_off_n", int'(soft_off_n), (m_pwr == 3) ? 0 : 1);
    endtask

    task automatic step(int n = 1);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            cyc++;
            compare();
        end
    endtask

    task automatic idle();
        bus_wr = 0; bus_rd = 0; bus_addr = 0; bus_wdata = 0;
        cpu_halt = 0; tmr_ovf = 0; lan_wake = 0; rtc_alarm = 0;
    endtask

    task automatic wr(int a, int d);
        bus_wr = 1; bus_addr = 3'(a); bus_wdata = 8'(d);
        step(); idle();
    endtask

    task automatic rd(int a);
        bus_rd = 1; bus_addr = 3'(a);
        step(); idle();
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        @(negedge clk);
        // R11: reset state
        bus_rd = 1; bus_addr = 0;
        step(2);
        chk("R11 reset sleep outs", int'({sus_lite_n, sus_deep_n, soft_off_n}), 7);
        chk("R11 reset cstate", int'(cstate), 0);
        rst_n = 1; idle();
        step(2);

        // R2: enable register readback
        wr(1, 'h15); rd(1);
        wr(1, 'h1f); rd(1);

        // R3 / R5: timer routed to smi then sci; R1 clear
        tmr_ovf = 1; step(); idle(); rd(0);
        wr(2, 'h01); step(2);
        wr(0, 'h01); rd(0);
        wr(1, 'h1e); tmr_ovf = 1; step(); idle(); step(2); wr(0, 'h1f); rd(0);

        // R4: ring rise held high, button rise
        ring_in = 1; bus_rd = 1; step(6); idle();
        wr(0, 'h02); ring_in = 1; step(4);
        ring_in = 0; pwr_btn = 1; bus_rd = 1; step(5); pwr_btn = 0; idle();
        wr(0, 'h1f); rd(0);

        // R6 / R7: C-state paths
        cpu_halt = 1; step(); idle(); step(2);
        wr(2, 'h00); step();
        rd(3); step(2);
        lan_wake = 1; step(); idle(); step(2);
        wr(0, 'h1f); rd(4); step(2); wr(2, 'h01); step();
        // concurrency: halt with level-2 read
        cpu_halt = 1; bus_rd = 1; bus_addr = 3; step(); idle(); step(); wr(2, 'h00);

        // concurrency R1: W1C and event on same bit
        bus_wr = 1; bus_addr = 0; bus_wdata = 'h04; lan_wake = 1; step(); idle(); rd(0);
        wr(0, 'h1f);

        // R8: reserved code, then light sleep, sleep write while asleep ignored
        wr(2, 'h10 | (3 << 1)); step();
        wr(2, 'h10 | (0 << 1)); step();
        wr(2, 'h10 | (2 << 1)); step(2); rd(2);
        wr(2, 'h10 | (7 << 1)); step();
        // R10: network wake
        lan_wake = 1; step(); idle(); step(2); rd(0); wr(0, 'h1f);

        // deep sleep; disabled RTC and timer do not wake
        wr(1, 'h0e);
        wr(2, 'h10 | (5 << 1)); step();
        rtc_alarm = 1; step(); idle(); tmr_ovf = 1; step(); idle(); step(3);
        wr(1, 'h1e); step(2); rd(0); wr(0, 'h1f);

        // soft-off, button wake
        wr(2, 'h10 | (7 << 1)); step(2);
        pwr_btn = 1; step(6); pwr_btn = 0; step(2); rd(0);
        wr(0, 'h1f);

        // R9 / R11: reset mid-sleep
        wr(2, 'h10 | (5 << 1)); step();
        rst_n = 0; step(2); rst_n = 1; step(2); rd(1);

        finish_run();
    end
endmodule